// File: doc/BRIEF.md
# Word-Clock Sync Window Monitor

This block keeps an internal sample-rate phase counter, clocked by the master clock, in step with an incoming word clock. The counter runs over one sample period of either 256 or 384 master-clock cycles. Every rising edge of the word clock is compared against the position where the counter expects it. An edge that lands inside an eight-cycle tolerance window leaves the counter alone. An edge outside the window, or any edge while the block is not locked, reloads the counter so that this edge becomes the new reference.

An active-low window-control input requests a forced realignment. While the request is held, the first word-clock rising edge is skipped and the second one realigns the counter, whatever its phase. The block reports three things: a one-cycle sample strobe once per period while locked, a lock flag, and a one-cycle pulse on every realignment. The word clock passes through a short synchronizer before its edge is detected. Downstream sample processing uses the strobe as its timing reference.

Top module: `wclk_sync_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `locked`, `sample_stb` and `resync_pulse` are all 0.
- R2: With `locked` at 0 and `win_ctl_n` high, any word-clock rising edge realigns the counter. `resync_pulse` and `locked` both go to 1 in the cycle that starts SYNC_STG+1 clock edges after the edge on which the rising word clock is first sampled.
- R3: `sample_stb` is 0 while unlocked. While locked it is 1 in the same cycle as each realignment pulse, and then once every period (256 or 384 cycles) on the grid that the last realignment set up.
- R4: While locked and in normal monitoring, an edge detected between 4 cycles early and 3 cycles late, relative to a whole number of periods after the last realignment, causes no pulse and does not move the grid.
- R5: While locked and in normal monitoring, an edge detected 5 or more cycles early, or 4 or more cycles late, causes a realignment pulse and restarts the grid on that edge.
- R6: `ratio_hi` = 0 selects a period of 256 master clocks, and `ratio_hi` = 1 selects 384.
- R7: When `win_ctl_n` is sampled low while idle, `locked` falls in the next cycle. Automatic realignment is suspended, and the first word-clock rising edge after that causes no pulse, even if it is out of the window.
- R8: The second word-clock rising edge while `win_ctl_n` stays low always realigns, even when it is in the window. `locked` returns to 1 in the same cycle as the pulse.
- R9: After a forced realignment, with `win_ctl_n` still low, the block performs only normal window monitoring: an in-window edge gives no pulse, and an out-of-window edge realigns.
- R10: If `win_ctl_n` returns high before the second edge, the forced request is dropped and `locked` stays 0. The next edge then realigns the counter as in R2.
- R11: `resync_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low clear; asynchronous assert |
| ratio_hi | input | 1 | Period select: 0 = 256 cycles, 1 = 384 cycles |
| wclk | input | 1 | Word clock; rising edge marks a sample frame |
| win_ctl_n | input | 1 | Low requests forced realignment; keep high otherwise |
| sample_stb | output | 1 | One-cycle strobe once per period while locked |
| locked | output | 1 | Counter is aligned to the word clock |
| resync_pulse | output | 1 | One-cycle pulse on every realignment |

## Verification
The realignment pulse, the lock flag and the strobe that goes with a realignment are all due SYNC_STG+1 clock edges after the rising word clock is first sampled. With the default two synchronizer stages that is three edges. The driver raises the word clock three negative edges before the intended detection cycle and queues the expected pulse cycle. The monitor compares pulses, lock state and strobe against the queue and against the expected grid at every falling edge. The lock drop caused by a forced request is due one edge after the request is sampled, so the bench updates its expected lock state just after that edge.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    // Forced-alignment sequencer states
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // normal monitoring, no request
        FS_ARM0 = 2'd1,   // request seen, waiting for first edge
        FS_ARM1 = 2'd2,   // first edge skipped, waiting for second
        FS_DONE = 2'd3    // forced alignment done, request still held
    } fsync_e;

    typedef struct packed {
        fsync_e fs;
        logic   locked;
        logic   pulse;
        logic   stb;
    } ctrl_st_t;

endpackage

// File: rtl/wsm_edge_det.sv
module wsm_edge_det #(
    parameter int SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    output logic rise
);

    logic sampled;

    generate
        if (SYNC_STG > 0) begin : g_sync
            logic [SYNC_STG-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = (chain_q << 1) | SYNC_STG'(wclk);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sampled = chain_q[SYNC_STG-1];
        end else begin : g_direct
            assign sampled = wclk;
        end
    endgenerate

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sampled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sampled & ~prev_q;

    // R11: two rises need a low sample between them
    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R11

endmodule

// File: rtl/wsm_phase_cnt.sv
module wsm_phase_cnt #(
    parameter int PER_LO = 256,
    parameter int PER_HI = 384,
    parameter int CNT_W  = $clog2(PER_HI)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hi,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_next
);

    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(PER_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(PER_HI - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = sel_hi ? LAST_HI : LAST_LO;
        st_d = st_q;
        if (load) begin
            st_d.cnt = '0;               // edge becomes the reference point
        end else if (st_q.cnt >= last) begin
            st_d.cnt = '0;               // period boundary
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        wrap_next = (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R6: with a steady period select the counter stays within the period
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sel_hi) |-> (st_q.cnt <= last)); // R6

endmodule

// File: rtl/wsm_window.sv
module wsm_window #(
    parameter int PER_LO = 256,
    parameter int PER_HI = 384,
    parameter int WIN_W  = 8,
    parameter int CNT_W  = $clog2(PER_HI)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             sel_hi,
    output logic             in_win
);

    // Expected edge: counter at last position of the period.
    // Window covers HALF cycles early through HALF-1 cycles late.
    localparam int HALF = WIN_W / 2;
    localparam logic [CNT_W-1:0] EARLY_LO = CNT_W'(PER_LO - 1 - HALF);
    localparam logic [CNT_W-1:0] EARLY_HI = CNT_W'(PER_HI - 1 - HALF);
    localparam logic [CNT_W-1:0] LATE_LIM = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] early_bound;

    always_comb begin
        early_bound = sel_hi ? EARLY_HI : EARLY_LO;
        in_win      = (cnt >= early_bound) || (cnt < LATE_LIM);
    end

endmodule

// File: rtl/wsm_sync_ctrl.sv
module wsm_sync_ctrl
    import wsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_ctl_n,
    input  logic rise,
    input  logic in_win,
    input  logic wrap_next,
    output logic resync,
    output logic locked,
    output logic pulse,
    output logic stb
);

    ctrl_st_t st_d, st_q;

    logic monitor_ok;
    logic forced_hit;
    logic auto_hit;

    // Decision logic kept apart from the state update so the counter load
    // and the strobe path do not form a block-level loop.
    assign monitor_ok = ((st_q.fs == FS_IDLE) &&  win_ctl_n) ||
                        ((st_q.fs == FS_DONE) && !win_ctl_n);
    assign forced_hit = (st_q.fs == FS_ARM1) && !win_ctl_n && rise;
    assign auto_hit   = monitor_ok && rise && (!st_q.locked || !in_win);
    assign resync     = forced_hit || auto_hit;

    always_comb begin
        st_d = st_q;

        unique case (st_q.fs)
            FS_IDLE: if (!win_ctl_n) st_d.fs = FS_ARM0;
            FS_ARM0: begin
                if (win_ctl_n) st_d.fs = FS_IDLE;
                else if (rise) st_d.fs = FS_ARM1;
            end
            FS_ARM1: begin
                if (win_ctl_n) st_d.fs = FS_IDLE;
                else if (rise) st_d.fs = FS_DONE;
            end
            FS_DONE: if (win_ctl_n) st_d.fs = FS_IDLE;
            default: st_d.fs = FS_IDLE;
        endcase

        if (resync) begin
            st_d.locked = 1'b1;
        end else if ((st_d.fs == FS_ARM0) || (st_d.fs == FS_ARM1)) begin
            st_d.locked = 1'b0;
        end

        st_d.pulse = resync;
        st_d.stb   = wrap_next && st_d.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fs     <= FS_IDLE;
            st_q.locked <= 1'b0;
            st_q.pulse  <= 1'b0;
            st_q.stb    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;
    assign pulse  = st_q.pulse;
    assign stb    = st_q.stb;

    AST_ARMED_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.fs == FS_ARM0) || (st_q.fs == FS_ARM1)) |-> !st_q.locked); // R7

    AST_FIRST_EDGE_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.fs == FS_ARM0) && !win_ctl_n && rise) |=> !st_q.pulse); // R7

    AST_SECOND_EDGE_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.fs == FS_ARM1) && !win_ctl_n && rise) |=> (st_q.pulse && st_q.locked)); // R8

    AST_UNLOCKED_EDGE_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.fs == FS_IDLE) && win_ctl_n && !st_q.locked && rise) |=> st_q.pulse); // R2

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse); // R11

endmodule

// File: rtl/wclk_sync_monitor.sv
module wclk_sync_monitor #(
    parameter int PER_LO   = 256,
    parameter int PER_HI   = 384,
    parameter int WIN_W    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_hi,
    input  logic wclk,
    input  logic win_ctl_n,
    output logic sample_stb,
    output logic locked,
    output logic resync_pulse
);

    localparam int CNT_W = $clog2(PER_HI);

    logic             rise;
    logic             in_win;
    logic             wrap_next;
    logic             resync;
    logic [CNT_W-1:0] cnt;

    wsm_edge_det #(
        .SYNC_STG (SYNC_STG)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .wclk  (wclk),
        .rise  (rise)
    );

    wsm_phase_cnt #(
        .PER_LO (PER_LO),
        .PER_HI (PER_HI),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_hi    (ratio_hi),
        .load      (resync),
        .cnt       (cnt),
        .wrap_next (wrap_next)
    );

    wsm_window #(
        .PER_LO (PER_LO),
        .PER_HI (PER_HI),
        .WIN_W  (WIN_W),
        .CNT_W  (CNT_W)
    ) u_win (
        .cnt    (cnt),
        .sel_hi (ratio_hi),
        .in_win (in_win)
    );

    wsm_sync_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_ctl_n (win_ctl_n),
        .rise      (rise),
        .in_win    (in_win),
        .wrap_next (wrap_next),
        .resync    (resync),
        .locked    (locked),
        .pulse     (resync_pulse),
        .stb       (sample_stb)
    );

    AST_STB_ON_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> sample_stb); // R3

    AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> locked); // R3

endmodule

// File: tb/wclk_sync_monitor_bench.sv
`timescale 1ns/1ps
module wclk_sync_monitor_bench;

    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ratio_hi = 1'b0;
    logic wclk = 1'b0;
    logic win_ctl_n = 1'b1;
    logic sample_stb, locked, resync_pulse;

    wclk_sync_monitor #(
        .PER_LO   (256),
        .PER_HI   (384),
        .WIN_W    (8),
        .SYNC_STG (SYNC)
    ) u_wclk_sync_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_hi     (ratio_hi),
        .wclk         (wclk),
        .win_ctl_n    (win_ctl_n),
        .sample_stb   (sample_stb),
        .locked       (locked),
        .resync_pulse (resync_pulse)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    int anchor = 0;
    int per = 256;
    bit b_locked = 1'b0;
    int fstage = 0;
    int n_pulse = 0;
    int last_stb = -1;
    bit prev_pulse = 1'b0;
    bit exp_stb;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: scoreboard for realignment pulses, lock flag and strobe grid
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            chk(1'b0, "R2/R5/R8 resync missing", 0, exp_q[0]);
            void'(exp_q.pop_front());
        end
        if (resync_pulse === 1'b1) begin
            n_pulse++;
            chk(!prev_pulse, "R11 pulse width", 2, 1);
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                chk(1'b1, "R2/R5/R8 resync", cyc, cyc);
                void'(exp_q.pop_front());
            end else begin
                chk(1'b0, "R2/R5/R8 unexpected resync", cyc, -1);
            end
        end
        prev_pulse = (resync_pulse === 1'b1);
        chk(locked === b_locked, "R7/R8 locked flag", int'(locked), int'(b_locked));
        exp_stb = b_locked && (((cyc - anchor) % per) == 0);
        chk(sample_stb === exp_stb, "R3 sample strobe", int'(sample_stb), int'(exp_stb));
        if (sample_stb === 1'b1) last_stb = cyc;
    end

    task automatic to_neg(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    // Driver: one word-clock rise whose detection cycle is j
    task automatic send_edge(input int j);
        int  off;
        bit  inwin;
        bit  rs;
        to_neg(j - SYNC - 1);
        wclk = 1'b1;
        while (cyc < j) after_edge();
        off = (((j - anchor) % per) + per) % per;
        if (off >= per / 2) off -= per;
        inwin = (off >= -4) && (off <= 3);
        rs = 1'b0;
        if (fstage == 1) begin
            fstage = 2;
        end else if (fstage == 2) begin
            rs = 1'b1;
            fstage = 3;
        end else begin
            rs = !b_locked || !inwin;
        end
        if (rs) begin
            exp_q.push_back(j);
            anchor = j;
            b_locked = 1'b1;
        end
        repeat (6) @(negedge clk);
        wclk = 1'b0;
    endtask

    task automatic force_low();
        @(negedge clk);
        win_ctl_n = 1'b0;
        after_edge();
        b_locked = 1'b0;
        fstage = 1;
    endtask

    task automatic force_high();
        @(negedge clk);
        win_ctl_n = 1'b1;
        after_edge();
        fstage = 0;
    endtask

    task automatic do_reset(input bit sel);
        after_edge();
        rst_n = 1'b0;
        ratio_hi = sel;
        win_ctl_n = 1'b1;
        b_locked = 1'b0;
        fstage = 0;
        per = sel ? 384 : 256;
        exp_q.delete();
        repeat (4) after_edge();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: all requirements actual=hang expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stimulus
        int a;
        int p0;
        do_reset(1'b0);

        // R1: outputs quiet right after clear
        @(negedge clk);
        chk(locked === 1'b0, "R1 locked after clear", int'(locked), 0);
        chk(sample_stb === 1'b0, "R1 strobe after clear", int'(sample_stb), 0);
        chk(resync_pulse === 1'b0, "R1 pulse after clear", int'(resync_pulse), 0);

        // R3: no strobe while unlocked over more than one period
        to_neg(cyc + 300);
        chk(last_stb == -1, "R3 strobe while unlocked", last_stb, -1);

        // R2: first edge aligns
        send_edge(cyc + 20);
        chk(n_pulse == 1, "R2 first edge pulse", n_pulse, 1);
        chk(locked === 1'b1, "R2 locked after first edge", int'(locked), 1);

        // R4: in-window edges at centre and both limits
        a = anchor;
        p0 = n_pulse;
        send_edge(a + 256);
        send_edge(a + 512 + 3);
        send_edge(a + 768 - 4);
        chk(n_pulse == p0, "R4 in-window edges", n_pulse, p0);
        chk(anchor == a, "R4 grid kept", anchor, a);

        // R5: just outside on either side
        send_edge(a + 1024 + 4);
        send_edge(anchor + 256 - 5);
        a = anchor;
        send_edge(a + 256);
        chk(n_pulse == p0 + 2, "R5 out-of-window edges", n_pulse, p0 + 2);

        // R7: request drops lock, first edge skipped though out of window
        force_low();
        @(negedge clk);
        chk(locked === 1'b0, "R7 lock dropped", int'(locked), 1'b0);
        a = anchor;
        p0 = n_pulse;
        send_edge(a + 256 + 50);
        chk(n_pulse == p0, "R7 first edge skipped", n_pulse, p0);

        // R8: second edge forces alignment
        send_edge(a + 512 + 100);
        chk(n_pulse == p0 + 1, "R8 forced pulse", n_pulse, p0 + 1);
        chk(locked === 1'b1, "R8 relocked", int'(locked), 1);

        // R9: request still held, normal monitoring only
        a = anchor;
        p0 = n_pulse;
        send_edge(a + 256 + 2);
        chk(n_pulse == p0, "R9 in-window while held", n_pulse, p0);
        send_edge(a + 512 + 10);
        chk(n_pulse == p0 + 1, "R9 out-of-window while held", n_pulse, p0 + 1);
        force_high();

        // R10: aborted request leaves block unlocked, next edge aligns
        force_low();
        a = anchor;
        p0 = n_pulse;
        send_edge(a + 256);
        force_high();
        @(negedge clk);
        chk(locked === 1'b0, "R10 unlocked after abort", int'(locked), 0);
        send_edge(a + 512);
        chk(n_pulse == p0 + 1, "R10 edge after abort aligns", n_pulse, p0 + 1);

        // R6: long period
        do_reset(1'b1);
        send_edge(cyc + 20);
        a = anchor;
        to_neg(a + 256);
        chk(sample_stb === 1'b0, "R6 no strobe at 256", int'(sample_stb), 0);
        p0 = n_pulse;
        send_edge(a + 384);
        chk(last_stb == a + 384, "R6 strobe at 384", last_stb, a + 384);
        chk(n_pulse == p0, "R6 aligned at 384", n_pulse, p0);
        send_edge(a + 384 + 256);
        chk(n_pulse == p0 + 1, "R6 off-grid at 384", n_pulse, p0 + 1);

        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R2/R5/R8 pending pulses", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule